// File: doc/BRIEF.md
# Masked Pattern Output Compare

This block is one compare channel of a general-purpose timer. It watches a free-running 16-bit count and, in the cycle where that count first equals a programmed 16-bit compare value, it writes a chosen bit pattern onto a group of five port pins in one step. A select register picks which pins the channel may drive. A level register holds the value each selected pin takes. Pins outside the selection are never touched by the event.

Software programs the channel over a byte-wide register bus. The compare value is loaded as two bytes. A status flag records each event and is cleared by writing a one to it. Toward the port, the block drives a 5-bit level vector and a 5-bit override vector. The surrounding port logic uses an override bit to choose the channel's level over its own value for that pin.

Register offsets: 0 holds the compare high byte, 1 the compare low byte, 2 the pin select, 3 the pin level, and 4 the event flag in bit 7. Byte bits 7..3 of the select and level registers belong to pin_out[4]..pin_out[0], in that order.

Top module: `mpoc_top`

## Requirements
- R1: After reset, the select, level and flag registers read 0x00, both compare bytes read 0xFF, and pin_out, pin_ovr and match_flag are all zero.
- R2: A write to offset 0 is held aside and does not change the active compare value. Offset 0 reads back the active high byte. A write to offset 1 loads {held byte, written byte} as the active compare value, and offsets 0 and 1 then read it back.
- R3: At offsets 2 and 3, byte bits 7..3 are stored and read back, with bit 7 belonging to pin_out[4] and bit 3 to pin_out[0]. Bits 2..0 ignore writes and always read 0.
- R4: An event occurs on a rising edge where count equals the active compare value and did not equal it at the previous edge. Loading a new compare value that equals the current count also counts as an event. On an event, every selected pin takes its level bit, and the new pin_out is visible right after that edge.
- R5: On an event, pins whose select bit is 0 keep their previous value.
- R6: While count stays equal to the compare value, only one event occurs.
- R7: An event sets the flag, which is seen both on match_flag and at offset 4 bit 7. Writing 1 to bit 7 of offset 4 clears the flag. Writing 0 has no effect. If an event and a clear happen on the same edge, the event wins.
- R8: pin_ovr[i] is 1 only while pin i is selected and an event has driven it since it was last selected. Clearing a select bit drops that pin's override at once.
- R9: pin_out changes only on an event. Between events it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Readback byte for addr (combinational) |
| count | input | 16 | Free-running timer count |
| pin_out | output | 5 | Levels for port pins 7..3 |
| pin_ovr | output | 5 | Per-pin strobe: use pin_out instead of the port's own value |
| match_flag | output | 1 | Compare event flag |

## Verification
The first pattern is a count that steps onto the compare value and then stalls there. It separates a level compare, which would fire every cycle, from a compare that fires only on the first matching cycle. The second pattern uses sparse select masks with all-ones and all-zeros levels. It shows whether unselected pins leak the level bits and whether the pin order is reversed. A flag clear landing on the same edge as an event, and a compare reload onto an already stalled count, probe the ordering at those edges. A long random walk of the count over a narrow window, mixed with random register writes, is then compared against the reference model on every cycle.

// File: rtl/mpoc_pkg.sv
package mpoc_pkg;

    localparam int CNT_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int FLAG_BIT = 7;

    typedef enum logic [ADDR_W-1:0] {
        OFS_CMP_HI = 3'd0,
        OFS_CMP_LO = 3'd1,
        OFS_SEL    = 3'd2,
        OFS_LVL    = 3'd3,
        OFS_FLAG   = 3'd4
    } reg_ofs_e;

endpackage

// File: rtl/mpoc_regs.sv
module mpoc_regs
    import mpoc_pkg::*;
#(
    parameter int NPIN = 5,
    parameter logic [CNT_W-1:0] RST_CMP = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              fire,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [NPIN-1:0]   sel_vec,
    output logic [NPIN-1:0]   lvl_vec,
    output logic              flag,
    output logic [BYTE_W-1:0] rdata
);

    localparam int TOP = BYTE_W - 1;

    typedef struct packed {
        logic [BYTE_W-1:0] hold;
        logic [CNT_W-1:0]  cmp;
        logic [NPIN-1:0]   sel;
        logic [NPIN-1:0]   lvl;
        logic              flag;
    } regs_t;

    regs_t q, d;

    // Next state: writes first, then an event may set the flag.
    // The event is applied last so that it wins over a clear on the same edge.
    always_comb begin
        d = q;
        if (wr_en) begin
            case (reg_ofs_e'(addr))
                OFS_CMP_HI: d.hold = wdata;
                OFS_CMP_LO: d.cmp  = {q.hold, wdata};
                OFS_SEL:    d.sel  = wdata[TOP -: NPIN];
                OFS_LVL:    d.lvl  = wdata[TOP -: NPIN];
                OFS_FLAG:   if (wdata[FLAG_BIT]) d.flag = 1'b0;
                default:    ;
            endcase
        end
        if (fire) d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.hold <= RST_CMP[CNT_W-1 -: BYTE_W];
            q.cmp  <= RST_CMP;
            q.sel  <= '0;
            q.lvl  <= '0;
            q.flag <= 1'b0;
        end else begin
            q <= d;
        end
    end

    // Readback. Bits that are not implemented stay zero.
    always_comb begin
        rdata = '0;
        case (reg_ofs_e'(addr))
            OFS_CMP_HI: rdata = q.cmp[CNT_W-1 -: BYTE_W];
            OFS_CMP_LO: rdata = q.cmp[BYTE_W-1:0];
            OFS_SEL:    rdata[TOP -: NPIN] = q.sel;
            OFS_LVL:    rdata[TOP -: NPIN] = q.lvl;
            OFS_FLAG:   rdata[FLAG_BIT] = q.flag;
            default:    rdata = '0;
        endcase
    end

    assign cmp_val = q.cmp;
    assign sel_vec = q.sel;
    assign lvl_vec = q.lvl;
    assign flag    = q.flag;

endmodule

// File: rtl/mpoc_match.sv
module mpoc_match
    import mpoc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             fire
);

    typedef struct packed {
        logic eq_prev;
    } match_t;

    match_t q, d;
    logic   eq;

    // A match fires only on its first cycle, so a stalled count cannot refire.
    always_comb begin
        eq        = (count == cmp_val);
        fire      = eq & ~q.eq_prev;
        d         = q;
        d.eq_prev = eq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/mpoc_pins.sv
module mpoc_pins #(
    parameter int NPIN = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [NPIN-1:0] sel_vec,
    input  logic [NPIN-1:0] lvl_vec,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_ovr
);

    typedef struct packed {
        logic [NPIN-1:0] lvl;
        logic [NPIN-1:0] drv;
    } pins_t;

    pins_t q, d;

    // One slice per pin. An event loads the level only where the pin is selected.
    // The driven bit remembers that this channel has owned the pin since it was selected.
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_comb begin
            d.lvl[i] = (fire && sel_vec[i]) ? lvl_vec[i] : q.lvl[i];
            d.drv[i] = sel_vec[i] & (q.drv[i] | fire);
        end
        assign pin_ovr[i] = sel_vec[i] & q.drv[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pin_out = q.lvl;

endmodule

// File: rtl/mpoc_top.sv
module mpoc_top
    import mpoc_pkg::*;
#(
    parameter int NPIN = 5,
    parameter logic [CNT_W-1:0] RST_CMP = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic [CNT_W-1:0]  count,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_ovr,
    output logic              match_flag
);

    logic [CNT_W-1:0] cmp_val;
    logic [NPIN-1:0]  sel_vec;
    logic [NPIN-1:0]  lvl_vec;
    logic             fire;

    mpoc_regs #(.NPIN(NPIN), .RST_CMP(RST_CMP)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .fire    (fire),
        .cmp_val (cmp_val),
        .sel_vec (sel_vec),
        .lvl_vec (lvl_vec),
        .flag    (match_flag),
        .rdata   (rdata)
    );

    mpoc_match u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .count   (count),
        .cmp_val (cmp_val),
        .fire    (fire)
    );

    mpoc_pins #(.NPIN(NPIN)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .sel_vec (sel_vec),
        .lvl_vec (lvl_vec),
        .pin_out (pin_out),
        .pin_ovr (pin_ovr)
    );

endmodule

// File: rtl/mpoc_chk.sv
module mpoc_chk #(
    parameter int NPIN = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            fire,
    input logic [NPIN-1:0] sel_vec,
    input logic [NPIN-1:0] lvl_vec,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] pin_ovr,
    input logic            match_flag
);

    p_fire_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> ((pin_out & $past(sel_vec)) == ($past(lvl_vec) & $past(sel_vec))));

    p_unsel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ $past(pin_out)) & ~$past(sel_vec)) == '0);

    p_fire_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> match_flag);

    p_ovr_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_ovr & ~sel_vec) == '0);

    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(pin_out));

endmodule

bind mpoc_top mpoc_chk #(.NPIN(NPIN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .sel_vec    (sel_vec),
    .lvl_vec    (lvl_vec),
    .pin_out    (pin_out),
    .pin_ovr    (pin_ovr),
    .match_flag (match_flag)
);

// File: tb/sim_mpoc_top.sv
module sim_mpoc_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  addr;
    logic [7:0]  wdata;
    logic [15:0] count;
    logic [7:0]  rdata;
    logic [4:0]  pin_out;
    logic [4:0]  pin_ovr;
    logic        match_flag;

    always #10 clk = ~clk;

    mpoc_top u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .count      (count),
        .pin_out    (pin_out),
        .pin_ovr    (pin_ovr),
        .match_flag (match_flag)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;
    bit live   = 0;

    // Reference model state
    logic [15:0] m_cmp;
    logic [7:0]  m_hold;
    logic [4:0]  m_sel, m_lvl, m_pins, m_own;
    bit          m_flag, m_prev, m_eq, m_hit;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_cmp[15:8];
            3'd1: return m_cmp[7:0];
            3'd2: return {m_sel, 3'b000};
            3'd3: return {m_lvl, 3'b000};
            3'd4: return {m_flag, 7'b0};
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmp = 16'hFFFF; m_hold = 8'hFF;
            m_sel = '0; m_lvl = '0; m_pins = '0; m_own = '0;
            m_flag = 0; m_prev = 0;
        end else begin
            m_eq   = (count == m_cmp);
            m_hit  = m_eq && !m_prev;
            m_prev = m_eq;
            for (int i = 0; i < 5; i++) begin
                if (m_hit && m_sel[i]) m_pins[i] = m_lvl[i];
                m_own[i] = m_sel[i] && (m_own[i] || m_hit);
            end
            if (wr_en && addr == 3'd4 && wdata[7]) m_flag = 0;
            if (m_hit) m_flag = 1;
            if (wr_en) begin
                case (addr)
                    3'd0: m_hold = wdata;
                    3'd1: m_cmp  = {m_hold, wdata};
                    3'd2: m_sel  = wdata[7:3];
                    3'd3: m_lvl  = wdata[7:3];
                    default: ;
                endcase
            end
        end
    end

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && live && !done) begin
            chk("R4,R5 pin_out vs model", {11'b0, pin_out}, {11'b0, m_pins});
            chk("R8 pin_ovr vs model", {11'b0, pin_ovr}, {11'b0, m_sel & m_own});
            chk("R7 match_flag vs model", {15'b0, match_flag}, {15'b0, m_flag});
            chk("R2,R3 rdata vs model", {8'b0, rdata}, {8'b0, model_rd(addr)});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        addr = a; #2;
        chk(tag, {8'b0, rdata}, {8'b0, exp});
    endtask

    task automatic setcnt(input logic [15:0] c);
        @(posedge clk); #1;
        count = c;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog (run) act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; wr_en = 0; addr = 0; wdata = 0; count = 16'h0000;
        repeat (3) @(posedge clk);
        #1 rst_n = 1; live = 1;

        // R1 reset state
        rd(3'd2, 8'h00, "R1 select reset");
        rd(3'd3, 8'h00, "R1 level reset");
        rd(3'd4, 8'h00, "R1 flag reset");
        rd(3'd0, 8'hFF, "R1 compare high reset");
        rd(3'd1, 8'hFF, "R1 compare low reset");
        chk("R1 pin_out reset", {11'b0, pin_out}, 16'h0);
        chk("R1 pin_ovr reset", {11'b0, pin_ovr}, 16'h0);
        chk("R1 match_flag reset", {15'b0, match_flag}, 16'h0);

        // R2 two-byte compare load
        wr(3'd0, 8'h12);
        rd(3'd0, 8'hFF, "R2 high byte held until low write");
        wr(3'd1, 8'h34);
        rd(3'd0, 8'h12, "R2 compare high after low write");
        rd(3'd1, 8'h34, "R2 compare low after low write");

        // R3 implemented bits only
        wr(3'd2, 8'hFF);
        rd(3'd2, 8'hF8, "R3 select low bits read zero");
        wr(3'd3, 8'h57);
        rd(3'd3, 8'h50, "R3 level low bits read zero");
        wr(3'd3, 8'hFF);
        wr(3'd2, 8'hA8);
        rd(3'd2, 8'hA8, "R3 select sparse pattern");

        // R4 event on first equal cycle, select 0xA8 -> pins 4,2,0
        setcnt(16'h1233); #2;
        chk("R4 no event before match", {11'b0, pin_out}, 16'h0);
        setcnt(16'h1234); #2;
        chk("R4 pins unchanged before edge", {11'b0, pin_out}, 16'h0);
        @(posedge clk); #1;
        chk("R4 selected pins loaded", {11'b0, pin_out}, 16'h0015);
        chk("R8 override on driven pins", {11'b0, pin_ovr}, 16'h0015);
        chk("R7 flag set on event", {15'b0, match_flag}, 16'h1);
        rd(3'd4, 8'h80, "R7 flag readback");

        // R6 stalled count fires once
        wr(3'd4, 8'h80);
        repeat (3) @(posedge clk); #1;
        chk("R6 no refire while stalled", {15'b0, match_flag}, 16'h0);

        // R7 writing zero does not clear
        setcnt(16'h1235);
        setcnt(16'h1234);
        @(posedge clk); #1;
        chk("R7 flag set again", {15'b0, match_flag}, 16'h1);
        wr(3'd4, 8'h7F);
        chk("R7 write without bit 7 ignored", {15'b0, match_flag}, 16'h1);

        // R5/R8 only pin 0 selected, level 0
        wr(3'd2, 8'h08);
        wr(3'd3, 8'h00);
        chk("R8 override drops with select", {11'b0, pin_ovr}, 16'h0001);
        setcnt(16'h1235);
        setcnt(16'h1234);
        @(posedge clk); #1;
        chk("R5 unselected pins keep value", {11'b0, pin_out}, 16'h0014);

        // R7 event and clear on the same edge
        setcnt(16'h1235);
        wr(3'd4, 8'h80);
        chk("R7 flag cleared", {15'b0, match_flag}, 16'h0);
        @(posedge clk); #1;
        count = 16'h1234; wr_en = 1; addr = 3'd4; wdata = 8'h80;
        @(posedge clk); #1;
        wr_en = 0;
        chk("R7 event wins over clear", {15'b0, match_flag}, 16'h1);

        // R4 reload compare onto a stalled count
        wr(3'd2, 8'hF8);
        wr(3'd3, 8'hF8);
        setcnt(16'h0042);
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h42);
        chk("R4 no event at reload edge", {11'b0, pin_out}, 16'h0014);
        @(posedge clk); #1;
        chk("R4 reload onto count fires", {11'b0, pin_out}, 16'h001F);

        // R9 hold between events
        for (int k = 1; k < 6; k++) setcnt(16'h0042 + 16'(k));
        #2;
        chk("R9 pins hold between events", {11'b0, pin_out}, 16'h001F);

        // Random walk over a narrow window with random writes
        for (int n = 0; n < 600; n++) begin
            @(posedge clk); #1;
            wr_en = ($urandom % 4 == 0);
            addr  = 3'($urandom % 5);
            wdata = 8'($urandom);
            if (addr == 3'd0) wdata = 8'h00;
            if (addr == 3'd1) wdata = 8'($urandom % 8);
            if ($urandom % 3 != 0) count = 16'($urandom % 8);
        end
        @(posedge clk); #1;
        wr_en = 0;
        @(negedge clk); #1;

        done = 1;
        summary();
        $finish;
    end

endmodule